// File: doc/BRIEF.md
# Card Clock Divider with Bypass

This block derives the card clock of an SD/MMC host from the faster module clock. Configuration arrives as plain input levels: an 8-bit divider value, an enable, a bypass select, a variant strap that picks one of two division laws, a power-save select with a busy indication from the command and data paths, and a flow-control enable with a FIFO stall request. The block drives the card clock, a one-cycle strobe in the module-clock domain that marks each rising card-clock edge, and the bus-width code handed to the data path.

In the default variant one card-clock period lasts 2*(N+1) module cycles. In the alternate variant it lasts N+2 module cycles. In bypass mode the module clock is passed straight through. The alternate variant passes it inverted, so the card sees the opposite edge. A new divider value is loaded only when a period wraps, so a change never shortens a pulse. Clock gating for power save and FIFO flow control freezes the divider phase and resumes it later. A running phase is never cut short.

Top module: `card_clk_div`

## Requirements
- R1: With the default strap (alt_law_i=0) and bypass off, the period between strobes is 2*(N+1) module cycles, and the card clock is high for N+1 of them.
- R2: With the alternate strap (alt_law_i=1) and bypass off, the period is N+2 module cycles, and the card clock is high for floor((N+2)/2) of them.
- R3: With bypass on and the clock running, cclk_o follows clk_i in the default variant and is the inverse of clk_i in the alternate variant, and cclk_edge_o is high in every cycle.
- R4: While en_i is low, cclk_o is low and no strobe is produced, in divided and in bypass mode.
- R5: In the alternate variant, flow_en_i=1 together with fifo_stall_i=1 stops the card clock, and the output level is held. In the default variant the stall request has no effect.
- R6: With pwr_save_i=1 the clock advances only while busy_i=1. Otherwise it is held and no strobe is produced.
- R7: A divider change takes effect at the next terminal count. The period in progress completes with the old value.
- R8: The width code is 00 for 1-bit, 01 for 4-bit and 10 for 8-bit. The code 10 passes only in the alternate variant. Code 11, or 10 in the default variant, yields 00. width_o is registered with one cycle of latency.
- R9: In divided mode the strobe is one cycle wide, coincides with the cycle in which cclk_o goes high, and never occurs in two consecutive cycles.
- R10: After reset, cclk_o, cclk_edge_o and width_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Card clock enable |
| bypass_i | input | 1 | Pass module clock through undivided |
| alt_law_i | input | 1 | Variant strap: 0 = 2*(N+1) law, 1 = N+2 law |
| div_i | input | 8 | Divider value N |
| pwr_save_i | input | 1 | Run the clock only while busy |
| busy_i | input | 1 | Command or data path busy |
| flow_en_i | input | 1 | Hardware flow-control enable (alternate variant) |
| fifo_stall_i | input | 1 | FIFO would underrun or overrun |
| width_i | input | 2 | Requested bus-width code |
| cclk_o | output | 1 | Card clock |
| cclk_edge_o | output | 1 | Strobe marking a rising card-clock edge |
| width_o | output | 2 | Bus-width code passed to the data path |

## Verification
Periods and high times are measured for N = 0, 3 and 7 under the default law and N = 0, 1 and 5 under the alternate law. Odd alternate periods show whether the high phase is rounded down. Bypass is sampled on both clock phases in each variant, which tells the inverted output apart from the plain one. A divider change made just after a strobe must give one old period and then one new one. Stall and power-save windows are run in both variants and with busy toggled, which separates freezing from ignoring.

// File: rtl/cclk_div_pkg.sv
`timescale 1ns/1ps
package cclk_div_pkg;
  typedef enum logic [1:0] {
    BW_1   = 2'b00,
    BW_4   = 2'b01,
    BW_8   = 2'b10,
    BW_RSV = 2'b11
  } bus_width_e;
endpackage

// File: rtl/cclk_period.sv
`timescale 1ns/1ps
module cclk_period #(
  parameter int DIV_W = 8,
  parameter int CNT_W = DIV_W + 2
) (
  input  logic [DIV_W-1:0] div_i,
  input  logic             alt_law_i,
  output logic [CNT_W-1:0] period_o
);
  logic [CNT_W-1:0] n_ext;
  assign n_ext    = CNT_W'(div_i);
  assign period_o = alt_law_i ? (n_ext + CNT_W'(2)) : ((n_ext + CNT_W'(1)) << 1);
endmodule

// File: rtl/cclk_run_gate.sv
`timescale 1ns/1ps
module cclk_run_gate (
  input  logic en_i,
  input  logic alt_law_i,
  input  logic pwr_save_i,
  input  logic busy_i,
  input  logic flow_en_i,
  input  logic fifo_stall_i,
  output logic run_o
);
  logic idle_hold, flow_hold;
  assign idle_hold = pwr_save_i & ~busy_i;
  assign flow_hold = alt_law_i & flow_en_i & fifo_stall_i;
  assign run_o     = en_i & ~idle_hold & ~flow_hold;
endmodule

// File: rtl/cclk_core.sv
`timescale 1ns/1ps
module cclk_core #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             cclk_o,
  output logic             edge_o
);
  logic [CNT_W-1:0] cnt_q, per_q, hi_len, cnt_nxt;

  assign hi_len  = per_q >> 1;
  assign cnt_nxt = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      per_q  <= CNT_W'(2);
      cclk_o <= 1'b0;
      edge_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      per_q  <= period_i;
      cclk_o <= 1'b0;
      edge_o <= 1'b0;
    end else if (!run_i) begin
      edge_o <= 1'b0;
    end else if (cnt_nxt == per_q) begin
      // terminal count: start a new period and pick up the divider
      cnt_q  <= '0;
      per_q  <= period_i;
      cclk_o <= 1'b1;
      edge_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_nxt;
      edge_o <= 1'b0;
      if (cnt_nxt == hi_len) cclk_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cclk_width.sv
`timescale 1ns/1ps
module cclk_width
  import cclk_div_pkg::*;
#(
  parameter bit WIDE_EN = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       alt_law_i,
  input  logic [1:0] width_i,
  output logic [1:0] width_o
);
  bus_width_e req, granted;
  assign req = bus_width_e'(width_i);

  generate
    if (WIDE_EN) begin : g_wide
      always_comb begin
        unique case (req)
          BW_4:    granted = BW_4;
          BW_8:    granted = alt_law_i ? BW_8 : BW_1;
          default: granted = BW_1;
        endcase
      end
    end else begin : g_narrow
      always_comb granted = (req == BW_4) ? BW_4 : BW_1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) width_o <= BW_1;
    else         width_o <= granted;
  end
endmodule

// File: rtl/card_clk_div.sv
`timescale 1ns/1ps
module card_clk_div #(
  parameter int DIV_W   = 8,
  parameter bit WIDE_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bypass_i,
  input  logic             alt_law_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             pwr_save_i,
  input  logic             busy_i,
  input  logic             flow_en_i,
  input  logic             fifo_stall_i,
  input  logic [1:0]       width_i,
  output logic             cclk_o,
  output logic             cclk_edge_o,
  output logic [1:0]       width_o
);
  localparam int CNT_W = DIV_W + 2;

  logic [CNT_W-1:0] period;
  logic             run, div_clk, div_edge;

  cclk_period #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_period (
    .div_i    (div_i),
    .alt_law_i(alt_law_i),
    .period_o (period)
  );

  cclk_run_gate u_gate (
    .en_i        (en_i),
    .alt_law_i   (alt_law_i),
    .pwr_save_i  (pwr_save_i),
    .busy_i      (busy_i),
    .flow_en_i   (flow_en_i),
    .fifo_stall_i(fifo_stall_i),
    .run_o       (run)
  );

  cclk_core #(.CNT_W(CNT_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .run_i   (run),
    .period_i(period),
    .cclk_o  (div_clk),
    .edge_o  (div_edge)
  );

  cclk_width #(.WIDE_EN(WIDE_EN)) u_width (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .alt_law_i(alt_law_i),
    .width_i  (width_i),
    .width_o  (width_o)
  );

  // bypass: alternate variant presents the inverted module clock
  assign cclk_o      = bypass_i ? (run & (clk_i ^ alt_law_i)) : div_clk;
  assign cclk_edge_o = bypass_i ? run : div_edge;
endmodule

// File: rtl/cclk_div_chk.sv
`timescale 1ns/1ps
module cclk_div_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             bypass_i,
  input logic             alt_law_i,
  input logic [DIV_W-1:0] div_i,
  input logic             pwr_save_i,
  input logic             busy_i,
  input logic             flow_en_i,
  input logic             fifo_stall_i,
  input logic [1:0]       width_i,
  input logic             cclk_o,
  input logic             cclk_edge_o,
  input logic [1:0]       width_o
);
  p_edge_marks_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass_i && cclk_edge_o) |-> cclk_o);

  p_edge_not_back_to_back_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass_i && cclk_edge_o) |=> (bypass_i || !cclk_edge_o));

  p_off_no_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && $past(!en_i)) |-> (!cclk_edge_o && !cclk_o));

  p_stall_holds_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(alt_law_i && flow_en_i && fifo_stall_i && en_i && !bypass_i) && !bypass_i && en_i)
      |-> $stable(cclk_o));

  p_idle_no_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pwr_save_i && !busy_i && !bypass_i) && !bypass_i) |-> !cclk_edge_o);

  p_wide_only_alt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_o == 2'b10) |-> $past(alt_law_i));
endmodule

bind card_clk_div cclk_div_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/card_clk_div_tb.sv
`timescale 1ns/1ps
module card_clk_div_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0, bypass_i = 1'b0, alt_law_i = 1'b0;
  logic [7:0] div_i = 8'd0;
  logic       pwr_save_i = 1'b0, busy_i = 1'b0, flow_en_i = 1'b0, fifo_stall_i = 1'b0;
  logic [1:0] width_i = 2'b00;
  logic       cclk_o, cclk_edge_o;
  logic [1:0] width_o;

  int n_run = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  card_clk_div u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .bypass_i(bypass_i),
    .alt_law_i(alt_law_i), .div_i(div_i), .pwr_save_i(pwr_save_i), .busy_i(busy_i),
    .flow_en_i(flow_en_i), .fifo_stall_i(fifo_stall_i), .width_i(width_i),
    .cclk_o(cclk_o), .cclk_edge_o(cclk_edge_o), .width_o(width_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(output int per, output int hi);
    int g = 0;
    while (!cclk_edge_o && g < 3000) begin @(negedge clk_i); g++; end
    per = 0; hi = 0;
    do begin
      if (cclk_o) hi++;
      per++;
      @(negedge clk_i);
    end while (!cclk_edge_o && per < 3000);
  endtask

  task automatic count_strobes(input int win, output int n, output bit lvl_stable);
    logic first;
    n = 0; lvl_stable = 1'b1; first = cclk_o;
    for (int i = 0; i < win; i++) begin
      @(negedge clk_i);
      if (cclk_edge_o) n++;
      if (cclk_o !== first) lvl_stable = 1'b0;
    end
  endtask

  task automatic restart(input logic alt, input int n);
    @(negedge clk_i);
    en_i = 1'b0; alt_law_i = alt; div_i = 8'(n);
    @(negedge clk_i);
    en_i = 1'b1;
  endtask

  task automatic t_reset;
    chk(cclk_o == 1'b0, "R10 cclk", int'(cclk_o), 0);
    chk(cclk_edge_o == 1'b0, "R10 strobe", int'(cclk_edge_o), 0);
    chk(width_o == 2'b00, "R10 width", int'(width_o), 0);
  endtask

  task automatic t_law(input logic alt, input int n);
    int per, hi, ep, eh;
    restart(alt, n);
    measure(per, hi);
    measure(per, hi);
    ep = alt ? n + 2 : 2 * (n + 1);
    eh = ep / 2;
    chk(per == ep, alt ? "R2 period" : "R1 period", per, ep);
    chk(hi == eh, alt ? "R2 high" : "R1 high", hi, eh);
  endtask

  task automatic t_strobe_width;
    int n; bit st;
    restart(1'b0, 2);
    @(negedge clk_i);
    count_strobes(24, n, st);
    chk(n == 4, "R9 one strobe per period", n, 4);
  endtask

  task automatic t_bypass(input logic alt);
    restart(alt, 5);
    bypass_i = 1'b1;
    @(negedge clk_i);
    chk(cclk_o == alt, "R3 low phase", int'(cclk_o), int'(alt));
    chk(cclk_edge_o == 1'b1, "R3 strobe", int'(cclk_edge_o), 1);
    @(posedge clk_i); #2;
    chk(cclk_o == !alt, "R3 high phase", int'(cclk_o), int'(!alt));
    @(negedge clk_i);
    en_i = 1'b0;
    #1;
    chk(cclk_o == 1'b0 && cclk_edge_o == 1'b0, "R4 bypass off", int'(cclk_o), 0);
    @(posedge clk_i); #2;
    chk(cclk_o == 1'b0, "R4 bypass off high phase", int'(cclk_o), 0);
    bypass_i = 1'b0;
  endtask

  task automatic t_enable_off;
    int n; bit st;
    restart(1'b0, 0);
    repeat (5) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    count_strobes(16, n, st);
    chk(n == 0, "R4 no strobe", n, 0);
    chk(cclk_o == 1'b0 && st, "R4 clock low", int'(cclk_o), 0);
  endtask

  task automatic t_flow;
    int n; bit st;
    restart(1'b1, 3);
    repeat (7) @(negedge clk_i);
    flow_en_i = 1'b1; fifo_stall_i = 1'b1;
    @(negedge clk_i);
    count_strobes(20, n, st);
    chk(n == 0, "R5 stall no strobe", n, 0);
    chk(st, "R5 stall level held", int'(st), 1);
    alt_law_i = 1'b0;   // default law, N=3 -> period 8
    @(negedge clk_i);
    count_strobes(24, n, st);
    chk(n == 3, "R5 stall ignored in default", n, 3);
    flow_en_i = 1'b0; fifo_stall_i = 1'b0;
  endtask

  task automatic t_pwr_save;
    int n; bit st;
    restart(1'b0, 1);
    pwr_save_i = 1'b1; busy_i = 1'b0;
    @(negedge clk_i);
    count_strobes(20, n, st);
    chk(n == 0, "R6 idle held", n, 0);
    busy_i = 1'b1;
    count_strobes(20, n, st);
    chk(n == 5, "R6 busy runs", n, 5);
    pwr_save_i = 1'b0; busy_i = 1'b0;
  endtask

  task automatic t_div_change;
    int per, hi;
    restart(1'b0, 1);
    measure(per, hi);
    div_i = 8'd3;
    measure(per, hi);
    chk(per == 4, "R7 old period completes", per, 4);
    measure(per, hi);
    chk(per == 8, "R7 new period", per, 8);
  endtask

  task automatic t_width;
    @(negedge clk_i); alt_law_i = 1'b1; width_i = 2'b10;
    @(negedge clk_i);
    chk(width_o == 2'b10, "R8 8-bit alt", int'(width_o), 2);
    alt_law_i = 1'b0;
    @(negedge clk_i);
    chk(width_o == 2'b00, "R8 8-bit refused default", int'(width_o), 0);
    width_i = 2'b01;
    #1;
    chk(width_o == 2'b00, "R8 latency", int'(width_o), 0);
    @(negedge clk_i);
    chk(width_o == 2'b01, "R8 4-bit", int'(width_o), 1);
    width_i = 2'b11;
    @(negedge clk_i);
    chk(width_o == 2'b00, "R8 reserved", int'(width_o), 0);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_law(1'b0, 0);
    t_law(1'b0, 3);
    t_law(1'b0, 7);
    t_law(1'b1, 0);
    t_law(1'b1, 1);
    t_law(1'b1, 5);
    t_strobe_width();
    t_bypass(1'b0);
    t_bypass(1'b1);
    t_enable_off();
    t_flow();
    t_pwr_save();
    t_div_change();
    t_width();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule